// File: doc/BRIEF.md
# Narrow ROM Burst Read Sequencer

This block turns one cache-line read request into a sequence of byte accesses to an 8-bit ROM on a local bus. It assembles the returned bytes into four 64-bit beats and hands each beat to the requester as it completes. Each byte access occupies a slot whose length comes from a 4-bit first-access latency value. Each beat adds a fixed overhead. After the last beat comes a trailing interval and then a two-cycle high-impedance lockout, so that the ROM can release the shared data lines.

A requester raises `req` with a line address and a latency value. The sequencer accepts the request only while it is idle. It holds `bus_free` low from the first cycle after acceptance until the lockout has ended, and a bus arbiter uses that signal to keep every other memory access from starting. A whole burst lasts 4·(8·(lat+2)+3)+5+2 cycles. With a latency of 4 that comes to 211 cycles.

Top module: `rom_burst_seq`

## Requirements
- R1: After reset, `bus_free` is 1 and `rom_cs`, `rom_oe`, `beat_valid` and `ack` are 0.
- R2: When a request is accepted (`req` high while `bus_free` is 1), the first byte slot begins in the next cycle. Every byte slot lasts lat+2 cycles, with `rom_cs` and `rom_oe` both 1 throughout the slot.
- R3: `rom_addr` is {line, beat index (2 bits), byte index (3 bits)}. The byte index runs 0 to 7 inside each beat and the beat index runs 0 to 3, so the address steps low-order first. The address stays constant within a slot.
- R4: The byte read in the first slot of a beat lands in `beat_data[63:56]` and the byte read in the eighth slot lands in `beat_data[7:0]`. The ROM data is taken in the last cycle of each slot.
- R5: Each beat spans 8·(lat+2)+3 cycles. `beat_valid` is 1 for exactly one cycle, the last cycle of the beat, and `rom_cs` is 0 during the 3 overhead cycles.
- R6: `ack` is a one-cycle pulse that coincides with the fourth `beat_valid` pulse.
- R7: `bus_free` stays 0 for exactly 4·(8·(lat+2)+3)+7 cycles after acceptance. This covers a 5-cycle tail and then a 2-cycle lockout in which `rom_cs` is 0. For lat = 4 the count is 211.
- R8: The latency value is taken at acceptance. Changes to `lat_cfg` during a burst have no effect on that burst's timing.
- R9: A request is accepted only while idle. If `req` is held high, the next burst starts after `bus_free` has been 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Burst request, held until `ack` |
| req_line | input | 15 | Cache-line address (byte address bits 19:5) |
| lat_cfg | input | 4 | First-access latency value |
| ack | output | 1 | Burst complete, aligned with the fourth beat |
| rom_addr | output | 20 | ROM byte address |
| rom_cs | output | 1 | ROM chip select, active high |
| rom_oe | output | 1 | ROM output enable, active high |
| rom_data | input | 8 | ROM read data |
| beat_valid | output | 1 | `beat_data` holds a complete beat |
| beat_data | output | 64 | Assembled 64-bit beat |
| bus_free | output | 1 | No ROM burst or lockout in progress |

## Verification
All results are timed from the clock edge that accepts the request, which counts as cycle −1. The bench then keeps a cycle counter t, sampled at the falling edge. At each t it works out from lat alone whether a byte slot is open, which address is due, and whether t is the last cycle of a beat (t mod (8·(lat+2)+3) equal to its last value), where `beat_valid`, the packed data and, for beat 3, `ack` are expected. The counter then runs to cycle 4·(8·(lat+2)+3)+7, where `bus_free` must return to 1. The bench sweeps all sixteen latency values, scrambles `lat_cfg` right after acceptance, and runs one held-request burst to place the one-cycle idle gap.

// File: rtl/rom_burst_pkg.sv
package rom_burst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_BYTE  = 3'd1,
    PH_BEAT  = 3'd2,
    PH_TAIL  = 3'd3,
    PH_LOCK  = 3'd4
  } phase_e;

  // cycles spent on one byte access for a latency value
  function automatic int unsigned slot_len(input int unsigned lat);
    return lat + 2;
  endfunction

  // cycles for a full beat: all byte slots plus beat overhead
  function automatic int unsigned beat_len(input int unsigned lat,
                                           input int unsigned nbytes,
                                           input int unsigned ovh);
    return nbytes * slot_len(lat) + ovh;
  endfunction

  // cycles bus_free stays low for one burst
  function automatic int unsigned burst_len(input int unsigned lat,
                                            input int unsigned nbytes,
                                            input int unsigned nbeats,
                                            input int unsigned ovh,
                                            input int unsigned tail,
                                            input int unsigned lock);
    return nbeats * beat_len(lat, nbytes, ovh) + tail + lock;
  endfunction

endpackage

// File: rtl/rb_phase_timer.sv
module rb_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rb_burst_ctrl.sv
module rb_burst_ctrl
  import rom_burst_pkg::*;
#(
  parameter int LAT_W  = 4,
  parameter int BEATS  = 4,
  parameter int BPB    = 8,
  parameter int OVH    = 3,
  parameter int TAIL   = 5,
  parameter int LOCK   = 2,
  localparam int CW    = LAT_W + 1,
  localparam int BTW   = $clog2(BEATS),
  localparam int BYW   = $clog2(BPB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LAT_W-1:0] lat_cfg,
  output phase_e           phase,
  output logic [BTW-1:0]   beat_idx,
  output logic [BYW-1:0]   byte_idx,
  output logic             accept,
  output logic             byte_done,
  output logic             beat_end
);
  logic [LAT_W-1:0] lat_q;
  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_exp;
  phase_e           phase_nx;

  rb_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign accept    = (phase == PH_IDLE) && req;
  assign byte_done = (phase == PH_BYTE) && tmr_exp;
  assign beat_end  = (phase == PH_BEAT) && tmr_exp;

  always_comb begin
    phase_nx = phase;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE: if (req) begin
        phase_nx = PH_BYTE;
        tmr_load = 1'b1;
        tmr_val  = {1'b0, lat_cfg} + 1'b1;
      end
      PH_BYTE: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (byte_idx == BYW'(BPB - 1)) begin
          phase_nx = PH_BEAT;
          tmr_val  = CW'(OVH - 1);
        end else begin
          tmr_val  = {1'b0, lat_q} + 1'b1;
        end
      end
      PH_BEAT: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (beat_idx == BTW'(BEATS - 1)) begin
          phase_nx = PH_TAIL;
          tmr_val  = CW'(TAIL - 1);
        end else begin
          phase_nx = PH_BYTE;
          tmr_val  = {1'b0, lat_q} + 1'b1;
        end
      end
      PH_TAIL: if (tmr_exp) begin
        phase_nx = PH_LOCK;
        tmr_load = 1'b1;
        tmr_val  = CW'(LOCK - 1);
      end
      PH_LOCK: if (tmr_exp) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      lat_q    <= '0;
      beat_idx <= '0;
      byte_idx <= '0;
    end else begin
      phase <= phase_nx;
      if (accept) begin
        lat_q    <= lat_cfg;
        beat_idx <= '0;
        byte_idx <= '0;
      end else begin
        if (byte_done) byte_idx <= byte_idx + 1'b1;
        if (beat_end && beat_idx != BTW'(BEATS - 1)) beat_idx <= beat_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rb_beat_packer.sv
module rb_beat_packer #(
  parameter int DW = 64,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [RW-1:0] din,
  output logic [DW-1:0] beat
);
  // earliest byte ends up in the top lane after a full beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat <= '0;
    else if (shift_en) beat <= {beat[DW-RW-1:0], din};
  end
endmodule

// File: rtl/rom_burst_seq.sv
module rom_burst_seq
  import rom_burst_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 64,
  parameter int RW    = 8,
  parameter int LAT_W = 4,
  parameter int BEATS = 4,
  parameter int OVH   = 3,
  parameter int TAIL  = 5,
  parameter int LOCK  = 2,
  localparam int BPB  = DW / RW,
  localparam int LSB  = $clog2(BEATS) + $clog2(BPB),
  localparam int LW   = AW - LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [LW-1:0]    req_line,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             ack,
  output logic [AW-1:0]    rom_addr,
  output logic             rom_cs,
  output logic             rom_oe,
  input  logic [RW-1:0]    rom_data,
  output logic             beat_valid,
  output logic [DW-1:0]    beat_data,
  output logic             bus_free
);
  localparam int BTW = $clog2(BEATS);
  localparam int BYW = $clog2(BPB);

  phase_e         phase;
  logic [BTW-1:0] beat_idx;
  logic [BYW-1:0] byte_idx;
  logic           accept;
  logic           slot_last;
  logic           beat_end;
  logic           in_lock;
  logic [LW-1:0]  line_q;

  rb_burst_ctrl #(
    .LAT_W (LAT_W), .BEATS (BEATS), .BPB (BPB),
    .OVH (OVH), .TAIL (TAIL), .LOCK (LOCK)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .lat_cfg   (lat_cfg),
    .phase     (phase),
    .beat_idx  (beat_idx),
    .byte_idx  (byte_idx),
    .accept    (accept),
    .byte_done (slot_last),
    .beat_end  (beat_end)
  );

  rb_beat_packer #(.DW(DW), .RW(RW)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (slot_last),
    .din      (rom_data),
    .beat     (beat_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_q <= '0;
    else if (accept) line_q <= req_line;
  end

  assign in_lock    = (phase == PH_LOCK);
  assign rom_addr   = {line_q, beat_idx, byte_idx};
  assign rom_cs     = (phase == PH_BYTE);
  assign rom_oe     = (phase == PH_BYTE);
  assign beat_valid = beat_end;
  assign ack        = beat_end && (beat_idx == BTW'(BEATS - 1));
  assign bus_free   = (phase == PH_IDLE);
endmodule

// File: rtl/rom_burst_chk.sv
module rom_burst_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          slot_last,
  input logic          in_lock,
  input logic          rom_cs,
  input logic [AW-1:0] rom_addr,
  input logic          beat_valid,
  input logic          ack,
  input logic          bus_free
);
  p_start_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rom_cs && !bus_free);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && !slot_last) |=> $stable(rom_addr));

  p_beat_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> !beat_valid);

  p_beat_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !rom_cs);

  p_ack_on_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> beat_valid);

  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> (!rom_cs && !bus_free));

  p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_lock) |-> bus_free);

  p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> bus_free);
endmodule

bind rom_burst_seq rom_burst_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .slot_last  (slot_last),
  .in_lock    (in_lock),
  .rom_cs     (rom_cs),
  .rom_addr   (rom_addr),
  .beat_valid (beat_valid),
  .ack        (ack),
  .bus_free   (bus_free)
);

// File: tb/tb_rom_burst_seq.sv
`timescale 1ns/1ps
module tb_rom_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [14:0] req_line = '0;
  logic [3:0]  lat_cfg = '0;
  logic        ack, rom_cs, rom_oe, beat_valid, bus_free;
  logic [19:0] rom_addr;
  logic [7:0]  rom_data;
  logic [63:0] beat_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] romf(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  assign rom_data = romf(rom_addr);

  rom_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_line(req_line),
    .lat_cfg(lat_cfg), .ack(ack), .rom_addr(rom_addr), .rom_cs(rom_cs),
    .rom_oe(rom_oe), .rom_data(rom_data), .beat_valid(beat_valid),
    .beat_data(beat_data), .bus_free(bus_free)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one burst; hold=1 keeps req high to test back-to-back start (R9)
  task automatic run_burst(input int lat, input logic [14:0] line, input bit hold);
    int bp, tot, low;
    logic [63:0] exp_beat;
    bp  = 8 * (lat + 2) + 3;
    tot = 4 * bp + 7;
    low = 0;
    req_line = line;
    lat_cfg  = 4'(lat);
    req      = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= tot + (hold ? 1 : 0); t++) begin
      @(negedge clk);
      if (t == 0) lat_cfg = ~4'(lat);   // R8: must not disturb this burst
      if (t < tot) begin
        int b, r, k;
        bit inb, bv;
        b   = t / bp;
        r   = t % bp;
        inb = (t < 4 * bp) && (r < 8 * (lat + 2));
        bv  = (t < 4 * bp) && (r == bp - 1);
        k   = r / (lat + 2);
        if (!bus_free) low++;
        chk(rom_cs == inb && rom_oe == inb, "R2/R5 select",
            {62'd0, rom_cs, rom_oe}, {62'd0, inb, inb});
        if (inb)
          chk(rom_addr == {line, 2'(b), 3'(k)}, "R3 address",
              64'(rom_addr), 64'({line, 2'(b), 3'(k)}));
        chk(beat_valid == bv, "R5 beat_valid", 64'(beat_valid), 64'(bv));
        chk(ack == (bv && b == 3), "R6 ack", 64'(ack), 64'(bv && b == 3));
        if (bv) begin
          exp_beat = '0;
          for (int j = 0; j < 8; j++)
            exp_beat = {exp_beat[55:0], romf({line, 2'(b), 3'(j)})};
          chk(beat_data == exp_beat, "R4 packing", beat_data, exp_beat);
        end
        if (ack && !hold) req = 1'b0;
      end else if (t == tot) begin
        chk(low == tot, "R7 low count", 64'(low), 64'(tot));
        chk(bus_free == 1'b1, "R7 release", 64'(bus_free), 64'd1);
        if (lat == 4) chk(low == 211, "R7 lat4 total", 64'(low), 64'd211);
      end else begin
        // R9: req still high, new burst must have started
        chk(bus_free == 1'b0 && rom_cs == 1'b1, "R9 restart",
            {62'd0, bus_free, rom_cs}, 64'd1);
        req = 1'b0;
      end
    end
    if (hold) begin
      while (!bus_free) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_free == 1'b1 && rom_cs == 1'b0 && rom_oe == 1'b0 &&
        beat_valid == 1'b0 && ack == 1'b0, "R1 reset",
        {59'd0, bus_free, rom_cs, rom_oe, beat_valid, ack}, 64'h10);
    rst_n = 1'b1;
    @(negedge clk);
    for (int l = 0; l < 16; l++)
      run_burst(l, 15'(l * 16'h0937 + 3), 1'b0);
    run_burst(0, 15'h7FFF, 1'b1);
    run_burst(4, 15'h2A55, 1'b0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule